// File: doc/BRIEF.md
# External Interrupt Trigger Controller

This block conditions four asynchronous external interrupt pins and turns them into clean, maskable interrupt requests. Each pin is brought into the clock domain through a two-flop synchroniser. A small per-line state machine then decides whether the line is pending, using the line's trigger mode. The mode can be level-high, level-low, rising edge, falling edge or either edge.

Software controls and observes all four lines through one 32-bit register. For each line the register holds a sense bit, a read-only status bit, a write-one clear bit, an enable bit, a both-edge bit and a level-select bit. Each line drives its own request output, and the four requests are also ORed into one combined output. A parameter chooses between two bit layouts of the register, one packed and one spaced out.

Each line's state machine has two states:
- `LN_IDLE`: nothing pending.
- `LN_PEND`: request latched or level active.

The transitions between them depend on the mode:
- In edge mode, `LN_IDLE` goes to `LN_PEND` on a qualifying edge.
- In edge mode, `LN_PEND` goes back to `LN_IDLE` only on a clear that does not coincide with a new qualifying edge.
- In level mode, the state follows the qualified level. It moves from `LN_IDLE` to `LN_PEND` while the level is active, and from `LN_PEND` to `LN_IDLE` while it is inactive.

Top module: `ext_irq_trigger_ctrl`

## Requirements
- R1: After reset the register reads 0, and `irq_line` and `irq_any` are 0. Every line is then masked and set to falling-edge mode.
- R2: The register places line n's fields at fixed offsets.
  - With `ALT_LAYOUT=0`: sense at bit n, status at n+4, clear at n+8, enable at n+12, both-edge at n+16 and level-select at n+20.
  - With `ALT_LAYOUT=1`: the same fields at n, n+5, n+10, n+15, n+20 and n+25.
  - Sense, enable, both-edge and level-select read back as written.
  - Writing to a status bit has no effect.
- R3: With level-select=0, both-edge=0 and sense=1, a rising pin edge sets the line's status, and a falling edge does not.
- R4: With level-select=0, both-edge=0 and sense=0, a falling pin edge sets the line's status, and a rising edge does not.
- R5: With level-select=0 and both-edge=1, either pin edge sets the line's status.
- R6: With level-select=1, status follows the synchronised pin. The line is active when the pin is high for sense=1, and when it is low for sense=0.
- R7: In edge mode, status is sticky until software writes 1 to the line's clear bit.
  - Several clear bits may be written in one access.
  - Clear bits always read 0.
- R8: When a qualifying edge and a clear reach a line in the same cycle, the status stays set.
- R9: `irq_line[n]` equals status AND enable for line n. A masked line still latches its status.
- R10: `irq_any` is the OR of the four `irq_line` bits.
- R11: A pin change made before clock edge k is visible in status and `irq_line` after edge k+2 and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | 4 | Asynchronous external interrupt pins |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Register read data (combinational from state) |
| irq_line | output | 4 | Per-line interrupt requests |
| irq_any | output | 1 | OR of all line requests |

## Verification
A pin change lands in status three rising edges after it is driven: two edges to cross the synchroniser and one for the line state register. The bench therefore drives pins on a falling edge and samples three falling edges later, and for R11 it also samples one cycle earlier to confirm the output is not yet set. A register write takes effect at the rising edge that follows the strobe, and a level-mode change shows in status one edge after that. The test for R8 places the clear exactly two edges after a pin change, which is the cycle in which the synchronised edge is seen.

// File: rtl/eitc_pkg.sv
package eitc_pkg;

    typedef enum logic {
        LN_IDLE = 1'b0,
        LN_PEND = 1'b1
    } line_state_e;

    typedef struct packed {
        logic sense;
        logic enable;
        logic both;
        logic level;
    } line_cfg_t;

    localparam int F_SENSE  = 0;
    localparam int F_STATUS = 1;
    localparam int F_CLEAR  = 2;
    localparam int F_ENABLE = 3;
    localparam int F_BOTH   = 4;
    localparam int F_LEVEL  = 5;
    localparam int N_FIELDS = 6;

    function automatic int fpos(input int field, input int line, input int stride);
        return line + field * stride;
    endfunction

endpackage

// File: rtl/eitc_sync.sv
module eitc_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[STAGES-2:0], din[b]};
        end
        assign dout[b] = chain[STAGES-1];
    end
endmodule

// File: rtl/eitc_line.sv
module eitc_line
    import eitc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      pin_s,
    input  line_cfg_t cfg,
    input  logic      clr,
    output logic      status
);
    line_state_e state, state_nx;
    logic        prev;
    logic        rise, fall, edge_evt, lvl_active;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= pin_s;
    end

    always_comb begin
        rise       = pin_s & ~prev;
        fall       = ~pin_s & prev;
        edge_evt   = cfg.both ? (rise | fall) : (cfg.sense ? rise : fall);
        lvl_active = (pin_s == cfg.sense);
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            LN_IDLE: begin
                if (cfg.level) state_nx = lvl_active ? LN_PEND : LN_IDLE;
                else           state_nx = edge_evt ? LN_PEND : LN_IDLE;
            end
            LN_PEND: begin
                if (cfg.level)               state_nx = lvl_active ? LN_PEND : LN_IDLE;
                else if (clr && !edge_evt)   state_nx = LN_IDLE;
                else                         state_nx = LN_PEND;
            end
            default: state_nx = LN_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= LN_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        status = (state == LN_PEND);
    end

    AST_EDGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg.level && edge_evt) |=> status); // R8

    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg.level && status && !clr) |=> status); // R7

    AST_LEVEL_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.level && (pin_s != cfg.sense)) |=> !status); // R6

endmodule

// File: rtl/ext_irq_trigger_ctrl.sv
module ext_irq_trigger_ctrl
    import eitc_pkg::*;
#(
    parameter int N_LINES    = 4,
    parameter int REG_W      = 32,
    parameter int ALT_LAYOUT = 0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] pin_in,
    input  logic               wr_en,
    input  logic [REG_W-1:0]   wr_data,
    output logic [REG_W-1:0]   rd_data,
    output logic [N_LINES-1:0] irq_line,
    output logic               irq_any
);
    localparam int STRIDE = (ALT_LAYOUT != 0) ? N_LINES + 1 : N_LINES;
    localparam int TOP_BIT = (N_LINES - 1) + (N_FIELDS - 1) * STRIDE;

    initial begin
        if (TOP_BIT >= REG_W) $error("register too narrow for layout");
    end

    logic [N_LINES-1:0] pin_s;
    logic [N_LINES-1:0] clr;
    logic [N_LINES-1:0] status;
    line_cfg_t          cfg [N_LINES];

    eitc_sync #(.WIDTH(N_LINES), .STAGES(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pin_in),
        .dout  (pin_s)
    );

    for (genvar n = 0; n < N_LINES; n++) begin : g_line
        localparam int P_SENSE  = fpos(F_SENSE,  n, STRIDE);
        localparam int P_STATUS = fpos(F_STATUS, n, STRIDE);
        localparam int P_CLEAR  = fpos(F_CLEAR,  n, STRIDE);
        localparam int P_ENABLE = fpos(F_ENABLE, n, STRIDE);
        localparam int P_BOTH   = fpos(F_BOTH,   n, STRIDE);
        localparam int P_LEVEL  = fpos(F_LEVEL,  n, STRIDE);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cfg[n] <= '0;
            end else if (wr_en) begin
                cfg[n].sense  <= wr_data[P_SENSE];
                cfg[n].enable <= wr_data[P_ENABLE];
                cfg[n].both   <= wr_data[P_BOTH];
                cfg[n].level  <= wr_data[P_LEVEL];
            end
        end

        assign clr[n] = wr_en & wr_data[P_CLEAR];

        eitc_line u_line (
            .clk    (clk),
            .rst_n  (rst_n),
            .pin_s  (pin_s[n]),
            .cfg    (cfg[n]),
            .clr    (clr[n]),
            .status (status[n])
        );

        assign irq_line[n] = status[n] & cfg[n].enable;

        AST_CFG_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en |=> (rd_data[P_ENABLE] == $past(wr_data[P_ENABLE]))
                   && (rd_data[P_LEVEL] == $past(wr_data[P_LEVEL]))); // R2

        AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en |=> !rd_data[P_CLEAR]); // R7

        AST_STATUS_RO: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_data[P_STATUS] && !rd_data[P_STATUS] && !cfg[n].level
             && pin_s[n] == $past(pin_s[n])) |=> !rd_data[P_STATUS]); // R2
    end

    always_comb begin
        rd_data = '0;
        for (int n = 0; n < N_LINES; n++) begin
            rd_data[fpos(F_SENSE,  n, STRIDE)] = cfg[n].sense;
            rd_data[fpos(F_STATUS, n, STRIDE)] = status[n];
            rd_data[fpos(F_ENABLE, n, STRIDE)] = cfg[n].enable;
            rd_data[fpos(F_BOTH,   n, STRIDE)] = cfg[n].both;
            rd_data[fpos(F_LEVEL,  n, STRIDE)] = cfg[n].level;
        end
    end

    assign irq_any = |irq_line;

endmodule

// File: tb/sim_ext_irq_trigger_ctrl.sv
`timescale 1ns/1ps
module sim_ext_irq_trigger_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  pins = 4'b0;
    logic        wr_en = 1'b0, wr_en1 = 1'b0;
    logic [31:0] wr_data = '0, wr_data1 = '0;
    logic [31:0] rd_data, rd_data1;
    logic [3:0]  irq_line, irq_line1;
    logic        irq_any, irq_any1;
    logic [31:0] shadow = '0;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    ext_irq_trigger_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .pin_in(pins), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .irq_line(irq_line), .irq_any(irq_any)
    );

    ext_irq_trigger_ctrl #(.ALT_LAYOUT(1)) u1 (
        .clk(clk), .rst_n(rst_n), .pin_in(pins), .wr_en(wr_en1), .wr_data(wr_data1),
        .rd_data(rd_data1), .irq_line(irq_line1), .irq_any(irq_any1)
    );

    function automatic logic [31:0] bitp(int field, int line);
        return 32'h1 << (line + field * 4);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [31:0] d);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic set_line(int n, bit sense, bit en, bit both, bit lvl);
        shadow &= ~(bitp(0, n) | bitp(3, n) | bitp(4, n) | bitp(5, n));
        if (sense) shadow |= bitp(0, n);
        if (en)    shadow |= bitp(3, n);
        if (both)  shadow |= bitp(4, n);
        if (lvl)   shadow |= bitp(5, n);
        wr(shadow);
    endtask

    task automatic clear_all();
        wr(shadow | 32'h0000_0F00);
    endtask

    function automatic bit st(int n);
        return rd_data[n + 4];
    endfunction

    task automatic t_reset();
        check("R1 rd_data", rd_data, 32'h0);
        check("R1 irq_line", {28'h0, irq_line}, 32'h0);
        check("R1 irq_any", {31'h0, irq_any}, 32'h0);
        check("R1 alt rd_data", rd_data1, 32'h0);
    endtask

    task automatic t_layout();
        wr(32'h00FF_F0FF);
        check("R2 readback default layout", rd_data, 32'h00FF_F00F);
        wr(32'h0);
        check("R2 write zero", rd_data, 32'h0);
        shadow = '0;
    endtask

    task automatic t_rise();
        set_line(0, 1, 1, 0, 0);
        pins[0] = 1'b1; step(3);
        check("R3 rise sets status", {31'h0, st(0)}, 32'h1);
        check("R3 rise irq_line", {28'h0, irq_line}, 32'h1);
        wr(shadow | bitp(2, 0));
        check("R7 clear line0", {31'h0, st(0)}, 32'h0);
        pins[0] = 1'b0; step(4);
        check("R3 fall ignored", {31'h0, st(0)}, 32'h0);
    endtask

    task automatic t_fall();
        set_line(1, 0, 1, 0, 0);
        pins[1] = 1'b1; step(4);
        check("R4 rise ignored", {31'h0, st(1)}, 32'h0);
        pins[1] = 1'b0; step(4);
        check("R4 fall sets status", {31'h0, st(1)}, 32'h1);
        clear_all();
    endtask

    task automatic t_both();
        set_line(2, 0, 1, 1, 0);
        pins[2] = 1'b1; step(4);
        check("R5 rise sets", {31'h0, st(2)}, 32'h1);
        clear_all();
        check("R5 cleared", {31'h0, st(2)}, 32'h0);
        pins[2] = 1'b0; step(4);
        check("R5 fall sets", {31'h0, st(2)}, 32'h1);
        set_line(2, 0, 0, 0, 0);
        clear_all();
    endtask

    task automatic t_level();
        set_line(3, 1, 1, 0, 1);
        step(1);
        check("R6 high-level inactive", {31'h0, st(3)}, 32'h0);
        pins[3] = 1'b1; step(3);
        check("R6 high-level active", {31'h0, st(3)}, 32'h1);
        pins[3] = 1'b0; step(3);
        check("R6 high-level drops", {31'h0, st(3)}, 32'h0);
        set_line(3, 0, 1, 0, 1);
        step(1);
        check("R6 low-level active", {31'h0, st(3)}, 32'h1);
        pins[3] = 1'b1; step(3);
        check("R6 low-level drops", {31'h0, st(3)}, 32'h0);
        pins[3] = 1'b0;
        set_line(3, 1, 0, 0, 0);
        step(3);
        clear_all();
    endtask

    task automatic t_clear_many();
        set_line(0, 1, 1, 0, 0);
        set_line(1, 1, 1, 0, 0);
        pins[1:0] = 2'b11; step(4);
        check("R7 both latched", {30'h0, st(1), st(0)}, 32'h3);
        check("R7 clear bits read 0", rd_data & 32'h0000_0F00, 32'h0);
        step(4);
        check("R7 sticky", {30'h0, st(1), st(0)}, 32'h3);
        wr(shadow | 32'h0000_00F0);
        check("R2 status write ignored", {30'h0, st(1), st(0)}, 32'h3);
        wr(shadow | bitp(2, 0) | bitp(2, 1));
        check("R7 two clears one write", {30'h0, st(1), st(0)}, 32'h0);
        pins[1:0] = 2'b00; step(4);
        clear_all();
    endtask

    task automatic t_edge_wins();
        set_line(0, 1, 1, 0, 0);
        pins[0] = 1'b1; step(2);
        wr(shadow | bitp(2, 0));
        check("R8 edge beats clear", {31'h0, st(0)}, 32'h1);
        clear_all();
        check("R8 later clear works", {31'h0, st(0)}, 32'h0);
        pins[0] = 1'b0; step(4);
    endtask

    task automatic t_mask_any();
        set_line(0, 1, 0, 0, 0);
        set_line(1, 1, 0, 0, 0);
        clear_all();
        pins[1] = 1'b1; step(4);
        check("R9 masked status latched", {31'h0, st(1)}, 32'h1);
        check("R9 masked irq_line", {28'h0, irq_line}, 32'h0);
        check("R10 irq_any masked", {31'h0, irq_any}, 32'h0);
        set_line(1, 1, 1, 0, 0);
        check("R9 enabled irq_line", {28'h0, irq_line}, 32'h2);
        check("R10 irq_any set", {31'h0, irq_any}, 32'h1);
        clear_all();
        check("R10 irq_any drops", {31'h0, irq_any}, 32'h0);
        pins[1] = 1'b0; step(4);
    endtask

    task automatic t_latency();
        set_line(2, 1, 1, 0, 0);
        clear_all();
        pins[2] = 1'b1; step(2);
        check("R11 not yet after 2 edges", {28'h0, irq_line}, 32'h0);
        step(1);
        check("R11 due after 3 edges", {28'h0, irq_line}, 32'h4);
        pins[2] = 1'b0; step(4);
        clear_all();
    endtask

    task automatic t_alt();
        wr_en1 = 1'b1; wr_data1 = 32'h0000_7C00;
        step(1);
        wr_data1 = (32'h1 << 0) | (32'h1 << 15);
        step(1);
        wr_en1 = 1'b0; wr_data1 = '0;
        check("R2 alt readback", rd_data1, 32'h0000_8001);
        pins[0] = 1'b1; step(4);
        check("R2 alt status at bit 5", rd_data1, 32'h0000_8021);
        check("R2 alt irq_line", {28'h0, irq_line1}, 32'h1);
        pins[0] = 1'b0; step(4);
    endtask

    initial begin
        step(3);
        t_reset();
        rst_n = 1'b1;
        step(2);
        t_layout();
        t_rise();
        t_fall();
        t_both();
        t_level();
        t_clear_many();
        t_edge_wins();
        t_mask_any();
        t_latency();
        t_alt();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule